// File: doc/BRIEF.md
# Multiplexed LCD Waveform Generator

This block sequences the drive levels for a segment LCD run at 1/4 duty. It has four common lines and a parameterised number of segment lines (34 by default). An oscillator-rate enable steps a scan timer. Each common phase lasts a fixed number of enabled ticks, and four phases make one frame. Every frame inverts the polarity so that the panel sees no net DC. For each common and segment pin the block emits a 2-bit level code. An analog stage outside the block turns that code into a voltage.

The display image is a flat vector with four bits per segment pin, one bit for each common. Run-time controls select the bias scheme (thirds or halves), blank the segments, enter power save, and inhibit the whole display. A thermometer count also turns the lowest segment pins into static general-purpose outputs. Those pins then output either rail, depending on the first image bit of the pin.

Top module: `lcd_mux_drive`

## Requirements
- R1: While `rst` is high, every level code is 0. On the first clock edge after reset, the outputs show common phase 0 with polarity 0.
- R2: The scan moves to the next common after 128 enabled ticks (an enabled tick is `osc_en`=1 and `pwr_save`=0). The commons are selected in the order 0,1,2,3. Polarity toggles each time the scan wraps from common 3 back to common 0, which happens every 512 ticks.
- R3: The level codes are 0=VSS, 1=low middle, 2=high middle, 3=full VLCD. The low middle level is 1/3 in third bias and 1/2 in half bias. With `half_bias`=0 the selected common outputs 3, the other commons 1, an on segment 0 and an off segment 2. When polarity is 1, every one of these values becomes 3 minus its value.
- R4: With `half_bias`=1 and polarity 0, the selected common outputs 3, the other commons 1, an on segment 0 and an off segment 3. With polarity 1 those values are 0, 1, 3 and 0.
- R5: Segment pin n (counted from 0) is on during common phase c when `disp_img[4n+c]` is 1.
- R6: With `blank`=1, every segment pin outputs its off level and the commons keep scanning.
- R7: With `pwr_save`=1, all common pins and all non-port segment pins output 0 and the scan timer holds its position. Port pins keep following their data.
- R8: With `inh_n`=0, every common and segment pin outputs 0, port pins included. The scan timer keeps running.
- R9: Segment pin n (n<8) acts as a port when `port_cnt` > n. Counts from 9 to 15 therefore act as 8.
- R10: A port pin n outputs 3 when `disp_img[4n]` is 1 and 0 when it is 0.
- R11: All outputs are registered. An input change first shows on the outputs after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_en | input | 1 | Oscillator tick enable |
| disp_img | input | 136 | Display image, four bits per segment pin |
| half_bias | input | 1 | 1 selects half bias, 0 selects third bias |
| blank | input | 1 | Force the segment off pattern |
| pwr_save | input | 1 | Power save: freeze the scan and ground the drive pins |
| inh_n | input | 1 | Active-low display inhibit |
| port_cnt | input | 4 | Number of low pins used as general-purpose outputs |
| com_lvl | output | 8 | Common level codes, 2 bits per common |
| seg_lvl | output | 68 | Segment level codes, 2 bits per pin |

## Verification
The assertions assume that all control inputs and the image are synchronous to `clk` and change only between rising edges. They also assume that reset is asserted at time zero, so the scan state is defined before it is checked. Any value of `port_cnt` is legal, including those above 8. The bench drives every input on the falling edge and holds it for at least one rising edge before it samples. It keeps its own count of enabled ticks to predict which common is selected and which polarity applies.

// File: rtl/lcd_mux_pkg.sv
package lcd_mux_pkg;

    localparam int COM_N = 4;
    localparam int PH_W  = $clog2(COM_N);

    typedef enum logic [1:0] {
        LV_VSS  = 2'd0,
        LV_LO   = 2'd1,
        LV_HI   = 2'd2,
        LV_FULL = 2'd3
    } lvl_e;

    typedef enum logic {
        BIAS_THIRD = 1'b0,
        BIAS_HALF  = 1'b1
    } bias_e;

    typedef struct packed {
        logic            pol;
        logic [PH_W-1:0] phase;
    } scan_t;

    // Common line level for the current phase and polarity.
    function automatic lvl_e com_level(logic sel, logic pol, bias_e b);
        if (sel)
            return pol ? LV_VSS : LV_FULL;
        if (b == BIAS_HALF)
            return LV_LO;
        return pol ? LV_HI : LV_LO;
    endfunction

    // Segment line level: on drives the rail opposite the selected common.
    function automatic lvl_e seg_level(logic on, logic pol, bias_e b);
        if (on)
            return pol ? LV_FULL : LV_VSS;
        if (b == BIAS_HALF)
            return pol ? LV_VSS : LV_FULL;
        return pol ? LV_LO : LV_HI;
    endfunction

endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
    import lcd_mux_pkg::*;
#(
    parameter int PHASE_TICKS = 128
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  step_en,
    output scan_t scan
);
    localparam int TW = $clog2(PHASE_TICKS);
    localparam logic [TW-1:0]   LAST_TICK = TW'(PHASE_TICKS - 1);
    localparam logic [PH_W-1:0] LAST_PH   = PH_W'(COM_N - 1);

    logic [TW-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick <= '0;
            scan <= '0;
        end else if (step_en) begin
            if (tick == LAST_TICK) begin
                tick <= '0;
                if (scan.phase == LAST_PH) begin
                    scan.phase <= '0;
                    scan.pol   <= ~scan.pol;
                end else begin
                    scan.phase <= scan.phase + PH_W'(1);
                end
            end else begin
                tick <= tick + TW'(1);
            end
        end
    end

    // R7: a stopped oscillator freezes the scan position
    p_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> ($stable(tick) && $stable(scan)));

    // R2: common only advances at the end of a phase
    p_phase_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (step_en && tick != LAST_TICK) |=> $stable(scan));

    // R2: polarity only flips on the wrap back to the first common
    p_pol_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (scan.pol != $past(scan.pol)) |-> (scan.phase == '0));

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
    import lcd_mux_pkg::*;
#(
    parameter int SEG_N = 34
) (
    input  logic                        clk,
    input  logic                        rst,
    input  scan_t                       scan,
    input  bias_e                       bias,
    input  logic                        blank,
    input  logic [4*SEG_N-1:0]          img,
    output logic [COM_N-1:0][1:0]       com_o,
    output logic [SEG_N-1:0][1:0]       seg_o
);
    logic [COM_N-1:0] com_rail;
    logic [SEG_N-1:0] seg_rail;

    for (genvar c = 0; c < COM_N; c++) begin : g_com
        always_comb begin
            com_o[c]    = com_level(scan.phase == PH_W'(c), scan.pol, bias);
            com_rail[c] = (com_o[c] == LV_FULL) || (com_o[c] == LV_VSS);
        end
    end

    for (genvar n = 0; n < SEG_N; n++) begin : g_seg
        logic [COM_N-1:0] bits;
        always_comb begin
            bits        = img[COM_N*n +: COM_N];
            seg_o[n]    = seg_level(bits[scan.phase] && !blank, scan.pol, bias);
            seg_rail[n] = (seg_o[n] == LV_FULL) || (seg_o[n] == LV_VSS);
        end
    end

    // R2: exactly one common sits on a rail in every phase
    p_single_select_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(com_rail) == 1);

    // R6: blanked third-bias segments stay at middle levels
    p_blank_mid_r6: assert property (@(posedge clk) disable iff (rst)
        (blank && bias == BIAS_THIRD) |-> (seg_rail == '0));

endmodule

// File: rtl/lcd_mux_drive.sv
module lcd_mux_drive
    import lcd_mux_pkg::*;
#(
    parameter int SEG_N       = 34,
    parameter int PORT_N      = 8,
    parameter int PORT_CNT_W  = 4,
    parameter int PHASE_TICKS = 128
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   osc_en,
    input  logic [4*SEG_N-1:0]     disp_img,
    input  logic                   half_bias,
    input  logic                   blank,
    input  logic                   pwr_save,
    input  logic                   inh_n,
    input  logic [PORT_CNT_W-1:0]  port_cnt,
    output logic [2*COM_N-1:0]     com_lvl,
    output logic [2*SEG_N-1:0]     seg_lvl
);
    scan_t                   scan;
    bias_e                   bias;
    logic [COM_N-1:0][1:0]   com_map, com_nxt, com_q;
    logic [SEG_N-1:0][1:0]   seg_map, seg_nxt, seg_q;

    assign bias = half_bias ? BIAS_HALF : BIAS_THIRD;

    lcd_scan_timer #(.PHASE_TICKS(PHASE_TICKS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .step_en (osc_en && !pwr_save),
        .scan    (scan)
    );

    lcd_level_map #(.SEG_N(SEG_N)) u_map (
        .clk   (clk),
        .rst   (rst),
        .scan  (scan),
        .bias  (bias),
        .blank (blank),
        .img   (disp_img),
        .com_o (com_map),
        .seg_o (seg_map)
    );

    for (genvar c = 0; c < COM_N; c++) begin : g_com_out
        assign com_nxt[c] = (!inh_n || pwr_save) ? LV_VSS : com_map[c];
    end

    for (genvar n = 0; n < SEG_N; n++) begin : g_seg_out
        if (n < PORT_N) begin : g_shared
            localparam logic [PORT_CNT_W-1:0] IDX = PORT_CNT_W'(n);
            always_comb begin
                if (!inh_n)
                    seg_nxt[n] = LV_VSS;
                else if (port_cnt > IDX)
                    seg_nxt[n] = disp_img[COM_N*n] ? LV_FULL : LV_VSS;
                else if (pwr_save)
                    seg_nxt[n] = LV_VSS;
                else
                    seg_nxt[n] = seg_map[n];
            end
        end else begin : g_plain
            assign seg_nxt[n] = (!inh_n || pwr_save) ? LV_VSS : seg_map[n];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            com_q <= '0;
            seg_q <= '0;
        end else begin
            com_q <= com_nxt;
            seg_q <= seg_nxt;
        end
    end

    assign com_lvl = com_q;
    assign seg_lvl = seg_q;

    // R8: inhibit grounds every pin on the following edge
    p_inhibit_dark_r8: assert property (@(posedge clk) disable iff (rst)
        !inh_n |=> (com_lvl == '0 && seg_lvl == '0));

    // R7: power save grounds the commons
    p_psave_com_r7: assert property (@(posedge clk) disable iff (rst)
        pwr_save |=> (com_lvl == '0));

    // R10: the first port pin follows its data bit at a rail
    p_port_level_r10: assert property (@(posedge clk) disable iff (rst)
        (inh_n && port_cnt != '0) |=>
            (seg_lvl[1:0] == ($past(disp_img[0]) ? 2'd3 : 2'd0)));

endmodule

// File: tb/tb_lcd_mux_drive.sv
module tb_lcd_mux_drive;
    localparam int SEG_N = 34;
    localparam int COMS  = 4;
    localparam int PORTS = 8;
    localparam int TICKS = 128;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               osc_en = 1'b1;
    logic [4*SEG_N-1:0] disp_img = '0;
    logic               half_bias = 1'b0;
    logic               blank = 1'b0;
    logic               pwr_save = 1'b0;
    logic               inh_n = 1'b1;
    logic [3:0]         port_cnt = 4'd0;
    logic [2*COMS-1:0]  com_lvl;
    logic [2*SEG_N-1:0] seg_lvl;

    int checks = 0;
    int errors = 0;
    int unsigned cnt = 0;
    int unsigned cnt_prev = 0;

    lcd_mux_drive dut (
        .clk(clk), .rst(rst), .osc_en(osc_en), .disp_img(disp_img),
        .half_bias(half_bias), .blank(blank), .pwr_save(pwr_save),
        .inh_n(inh_n), .port_cnt(port_cnt), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    always #4 clk = ~clk;

    // Reference tick count, taken from the R2/R7 rules
    always @(posedge clk) begin
        cnt_prev <= cnt;
        if (rst) cnt <= 0;
        else if (osc_en && !pwr_save) cnt <= cnt + 1;
    end

    function automatic logic [1:0] exp_com(int c);
        int  ph  = (cnt_prev / TICKS) % COMS;
        bit  pol = ((cnt_prev / (TICKS*COMS)) % 2) == 1;
        bit  sel = (c == ph);
        if (!inh_n || pwr_save) return 2'd0;
        if (sel) return pol ? 2'd0 : 2'd3;
        if (half_bias) return 2'd1;
        return pol ? 2'd2 : 2'd1;
    endfunction

    function automatic logic [1:0] exp_seg(int n);
        int  ph  = (cnt_prev / TICKS) % COMS;
        bit  pol = ((cnt_prev / (TICKS*COMS)) % 2) == 1;
        int  k   = (port_cnt > PORTS) ? PORTS : int'(port_cnt);
        bit  on;
        if (!inh_n) return 2'd0;
        if (n < k) return disp_img[4*n] ? 2'd3 : 2'd0;
        if (pwr_save) return 2'd0;
        on = disp_img[4*n + ph] && !blank;
        if (on) return pol ? 2'd3 : 2'd0;
        if (half_bias) return pol ? 2'd0 : 2'd3;
        return pol ? 2'd1 : 2'd2;
    endfunction

    task automatic check_pins(string tag);
        logic [2*COMS-1:0]  ec;
        logic [2*SEG_N-1:0] es;
        for (int c = 0; c < COMS; c++) ec[2*c +: 2] = exp_com(c);
        for (int n = 0; n < SEG_N; n++) es[2*n +: 2] = exp_seg(n);
        checks++;
        if (com_lvl !== ec || seg_lvl !== es) begin
            errors++;
            $display("FAIL %s: com=%h exp %h seg=%h exp %h", tag, com_lvl, ec, seg_lvl, es);
        end
    endtask

    task automatic set_img(int seed);
        for (int i = 0; i < 4*SEG_N; i++)
            disp_img[i] = ((i*seed + i/3 + seed/2) % 3) == 0;
    endtask

    task automatic sweep(string tag, int n, int step);
        for (int i = 0; i < n; i++) begin
            repeat (step) @(negedge clk);
            check_pins(tag);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        checks++;
        if (com_lvl !== '0 || seg_lvl !== '0) begin
            errors++;
            $display("FAIL R1 reset: com=%h seg=%h exp 0", com_lvl, seg_lvl);
        end
        rst = 1'b0;
        @(negedge clk);
        check_pins("R1 first phase");
    endtask

    task automatic t_third();
        set_img(7); half_bias = 1'b0;
        sweep("R2/R3/R5 third bias", 20, 61);
    endtask

    task automatic t_half();
        set_img(11); half_bias = 1'b1;
        sweep("R4/R5 half bias", 18, 67);
    endtask

    task automatic t_blank();
        blank = 1'b1; half_bias = 1'b0;
        sweep("R6 blank third", 6, 97);
        half_bias = 1'b1;
        sweep("R6 blank half", 6, 97);
        blank = 1'b0;
    endtask

    task automatic t_ports();
        set_img(5); half_bias = 1'b0;
        port_cnt = 4'd3;
        sweep("R9/R10 three ports", 4, 131);
        port_cnt = 4'd12;
        sweep("R9 clamp to eight", 4, 131);
        port_cnt = 4'd8;
        sweep("R9 eight ports", 2, 50);
        port_cnt = 4'd0;
        sweep("R9 no ports", 2, 50);
    endtask

    task automatic t_psave();
        port_cnt = 4'd5;
        pwr_save = 1'b1;
        sweep("R7 power save", 6, 53);
        set_img(13);
        sweep("R7 ports follow data", 2, 5);
        pwr_save = 1'b0;
        sweep("R7 scan resumes", 8, 71);
        port_cnt = 4'd0;
    endtask

    task automatic t_inhibit();
        port_cnt = 4'd8;
        inh_n = 1'b0;
        sweep("R8 inhibit", 6, 47);
        inh_n = 1'b1;
        sweep("R8 timer kept running", 6, 89);
        port_cnt = 4'd0;
    endtask

    task automatic t_latency();
        logic [2*COMS-1:0]  oc;
        logic [2*SEG_N-1:0] os;
        @(negedge clk);
        oc = com_lvl; os = seg_lvl;
        set_img(17); blank = 1'b1;
        #1;
        checks++;
        if (com_lvl !== oc || seg_lvl !== os) begin
            errors++;
            $display("FAIL R11 early change: com=%h exp %h seg=%h exp %h", com_lvl, oc, seg_lvl, os);
        end
        @(negedge clk);
        check_pins("R11 one edge later");
        blank = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_third();
        t_half();
        t_blank();
        t_ports();
        t_psave();
        t_inhibit();
        t_latency();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule